// File: doc/BRIEF.md
# Radio frame buffer and interrupt controller

This block is the digital core of a packet radio's shared frame store. A receive path fills a 128-byte buffer one byte at a time. A transmit engine drains the same buffer. A host reaches the buffer, the interrupt registers and the radio state through a small byte-wide register port that stands in for serial bus transactions. The block tracks the radio operating state and raises three interrupt sources: frame start, frame end and buffer underrun. All three are gathered on one level-sensitive interrupt line.

A received frame may be read while it is still arriving. Host reads of the buffer are held off for a fixed guard time after frame start. A read that overtakes the received data raises an underrun and marks the frame as suspect. A `buf_empty` output lets the host pace its reads. Transmission starts on either a rising edge of a pin or a command written to the state register. The transmit engine follows the write pointer, so the host can load the buffer and transmit it at the same time.

Top module: `rfbuf_irq_ctrl`

## Requirements
- R1: After reset, the state is idle (code 0), no interrupt is pending, the interrupt mask is 3'b111, `irq` is low, `buf_empty` is high and `tx_stb` is low.
- R2: The host port has four addresses: 0 is interrupt status, 1 is interrupt mask (read/write, bits [2:0]), 2 is state/command and 3 is buffer data. Read data appears on `hst_rdata` after the clock edge that samples `hst_rd`.
- R3: In the receive-listening state (code 2), `rx_sof` moves the block to busy-receive (code 3), sets pending bit 0 (frame start) and clears the buffer pointers and the suspect flag.
- R4: In busy-receive, each `rx_vld` byte is stored in order. The first byte is the length L, clamped to 127. When L further bytes have arrived, pending bit 1 (frame end) is set and the state returns to 2.
- R5: A buffer read within the guard window of 32 µs, expressed in clock cycles, after frame start is ignored: it returns 0 and does not advance the read pointer.
- R6: A buffer read in busy-receive with no unread byte returns 0 and sets pending bit 2 (underrun). It also sets bit 7 of the state read, and that bit stays set until the next frame start. Outside busy-receive, such a read only returns 0.
- R7: `buf_empty` is high exactly when the host has read every byte stored so far.
- R8: `irq` is the OR of pending bits ANDed with the mask. A status read returns the pending bits in [2:0] and clears them, except for any event arriving in the same cycle.
- R9: Transmission starts on a rising edge of `tx_pin` or on a write of code 2 to address 2 bits [2:0]. It is accepted only in PLL-on (code 1) or transmit-ready (code 5), which moves the block to busy-transmit (code 4). In any other state it has no effect.
- R10: In busy-transmit the engine sends one stored byte per cycle on `tx_stb`/`tx_byte` whenever it trails the write pointer. It stops after the length byte and L further bytes, sets pending bit 1 and returns to the state it started from.
- R11: Commands 1 (PLL-on), 3 (receive-listening), 4 (idle) and 5 (transmit-ready) are obeyed only outside the busy states. Entering code 1 or 5 by command clears the buffer pointers. Host buffer writes are accepted in codes 1, 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 2 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, registered |
| rx_sof | input | 1 | Receive frame start detected |
| rx_vld | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| tx_pin | input | 1 | Transmit start pin, rising edge |
| tx_stb | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| buf_empty | output | 1 | No unread received byte |
| irq | output | 1 | Masked interrupt request |

## Verification
The following changes become visible after the edge that samples their stimulus:
- the state, the pending bits, `irq` and `buf_empty`;
- register reads, on `hst_rdata`.

Transmit bytes appear one edge after the start command, or after the write that makes them available. The final byte's strobe and the frame-end flag share an edge. The bench drives every input just after a rising edge and samples one time unit later, so each result is read in the cycle it is due. The guard window is tested just after frame start (ignored) and again after the full window has passed (honoured).

// File: rtl/rfb_pkg.sv
`timescale 1ns/1ps
package rfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PLL   = 3'd1,
        ST_RXON  = 3'd2,
        ST_BRX   = 3'd3,
        ST_BTX   = 3'd4,
        ST_TXRDY = 3'd5
    } rstate_t;

    localparam logic [2:0] CMD_PLL   = 3'd1;
    localparam logic [2:0] CMD_TXGO  = 3'd2;
    localparam logic [2:0] CMD_RXON  = 3'd3;
    localparam logic [2:0] CMD_IDLE  = 3'd4;
    localparam logic [2:0] CMD_TXRDY = 3'd5;

    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_BUF  = 2'd3;

    localparam int NIRQ = 3;

    typedef struct packed {
        logic urun;
        logic fend;
        logic fsta;
    } irqv_t;

    function automatic logic [7:0] clamp_len(input logic [7:0] b, input int unsigned lim);
        logic [7:0] l;
        l = lim[7:0];
        return (b > l) ? l : b;
    endfunction

endpackage

// File: rtl/rfb_mem.sv
`timescale 1ns/1ps
module rfb_mem #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [7:0]    rb_data
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign ra_data = store[ra_addr];
    assign rb_data = store[rb_addr];
endmodule

// File: rtl/rfb_guard.sv
`timescale 1ns/1ps
module rfb_guard #(
    parameter int CYC = 1600
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic open
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= CMAX;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign open = (cnt == '0);

    // R5: a fresh frame start always closes the read window
    a_r5_guard_closes: assert property (@(posedge clk) disable iff (rst)
        load |=> !open);
endmodule

// File: rtl/rfb_irq.sv
`timescale 1ns/1ps
module rfb_irq
    import rfb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  irqv_t           set,
    input  logic            clr,
    input  logic            mask_we,
    input  logic [NIRQ-1:0] mask_d,
    output logic [NIRQ-1:0] pend,
    output logic [NIRQ-1:0] mask,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            mask <= '1;
        end else begin
            pend <= (clr ? '0 : pend) | set;
            if (mask_we) mask <= mask_d;
        end
    end

    assign irq = |(pend & mask);

    // R8: a status read with no new event leaves the line low
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (clr && set == '0) |=> (pend == '0 && !irq));
    // R8: an event is never lost
    a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
        set.fend |=> pend[1]);
endmodule

// File: rtl/rfbuf_irq_ctrl.sv
`timescale 1ns/1ps
module rfbuf_irq_ctrl
    import rfb_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int CLK_MHZ  = 50,
    parameter int GUARD_US = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hst_wr,
    input  logic       hst_rd,
    input  logic [1:0] hst_addr,
    input  logic [7:0] hst_wdata,
    output logic [7:0] hst_rdata,
    input  logic       rx_sof,
    input  logic       rx_vld,
    input  logic [7:0] rx_byte,
    input  logic       tx_pin,
    output logic       tx_stb,
    output logic [7:0] tx_byte,
    output logic       buf_empty,
    output logic       irq
);
    localparam int AW        = $clog2(DEPTH);
    localparam int GUARD_CYC = CLK_MHZ * GUARD_US;
    localparam int MAXLEN    = DEPTH - 1;
    localparam logic [AW:0] PFULL = (AW+1)'(DEPTH);

    rstate_t st;
    logic        pin_q, tx_ext, rx_bad;
    logic [AW:0] wr_ptr, rd_ptr, tx_ptr;
    logic [AW-1:0] rx_len, tx_len;
    logic [7:0]  rd_data, tx_cur, rx_clamp, tx_clamp;
    logic [NIRQ-1:0] pend, mask;
    irqv_t       ev;
    logic        rd_open;

    // host decode
    logic wr_buf, rd_buf, wr_ctl, rd_stat, wr_msk;
    logic [2:0] cmd;
    assign wr_buf  = hst_wr && hst_addr == A_BUF;
    assign rd_buf  = hst_rd && hst_addr == A_BUF;
    assign wr_ctl  = hst_wr && hst_addr == A_CTRL;
    assign wr_msk  = hst_wr && hst_addr == A_MASK;
    assign rd_stat = hst_rd && hst_addr == A_STAT;
    assign cmd     = hst_wdata[2:0];

    logic busy, tx_ready_st, tx_go, tx_acc, sof_take;
    assign busy        = (st == ST_BRX) || (st == ST_BTX);
    assign tx_ready_st = (st == ST_PLL) || (st == ST_TXRDY);
    assign tx_go       = (wr_ctl && cmd == CMD_TXGO) || (tx_pin && !pin_q);
    assign tx_acc      = tx_go && tx_ready_st;
    assign sof_take    = (st == ST_RXON) && rx_sof;

    logic cmd_clr;
    assign cmd_clr = wr_ctl && !busy && (cmd == CMD_PLL || cmd == CMD_TXRDY);

    // receive side
    logic rx_take, rx_last;
    assign rx_clamp = clamp_len(rx_byte, MAXLEN);
    assign rx_take  = (st == ST_BRX) && rx_vld && (wr_ptr < PFULL);
    assign rx_last  = rx_take && ((wr_ptr == '0) ? (rx_clamp == 8'd0)
                                                 : (wr_ptr == {1'b0, rx_len}));

    // host buffer access
    logic hw_take, rd_have, rd_take, urun;
    assign hw_take = wr_buf && (tx_ready_st || st == ST_BTX) && (wr_ptr < PFULL);
    assign rd_have = rd_ptr < wr_ptr;
    assign rd_take = rd_buf && rd_open && rd_have;
    assign urun    = rd_buf && rd_open && !rd_have && (st == ST_BRX);

    // transmit engine
    logic tx_send, tx_last;
    logic [AW-1:0] tx_len_now;
    assign tx_clamp   = clamp_len(tx_cur, MAXLEN);
    assign tx_send    = (st == ST_BTX) && (tx_ptr < wr_ptr);
    assign tx_len_now = (tx_ptr == '0) ? tx_clamp[AW-1:0] : tx_len;
    assign tx_last    = tx_send && (tx_ptr == {1'b0, tx_len_now});

    assign ev = '{urun: urun, fend: rx_last || tx_last, fsta: sof_take};

    rfb_mem #(.DEPTH(DEPTH), .AW(AW)) mem_i (
        .clk     (clk),
        .we      (rx_take || hw_take),
        .waddr   (wr_ptr[AW-1:0]),
        .wdata   (rx_take ? rx_byte : hst_wdata),
        .ra_addr (rd_ptr[AW-1:0]),
        .ra_data (rd_data),
        .rb_addr (tx_ptr[AW-1:0]),
        .rb_data (tx_cur)
    );

    rfb_guard #(.CYC(GUARD_CYC)) guard_i (
        .clk  (clk),
        .rst  (rst),
        .load (sof_take),
        .open (rd_open)
    );

    rfb_irq irq_i (
        .clk     (clk),
        .rst     (rst),
        .set     (ev),
        .clr     (rd_stat),
        .mask_we (wr_msk),
        .mask_d  (hst_wdata[NIRQ-1:0]),
        .pend    (pend),
        .mask    (mask),
        .irq     (irq)
    );

    // state
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            tx_ext <= 1'b0;
        end else if (sof_take) begin
            st <= ST_BRX;
        end else if (rx_last) begin
            st <= ST_RXON;
        end else if (tx_last) begin
            st <= tx_ext ? ST_TXRDY : ST_PLL;
        end else if (tx_acc) begin
            st     <= ST_BTX;
            tx_ext <= (st == ST_TXRDY);
        end else if (wr_ctl && !busy) begin
            case (cmd)
                CMD_PLL:   st <= ST_PLL;
                CMD_RXON:  st <= ST_RXON;
                CMD_IDLE:  st <= ST_IDLE;
                CMD_TXRDY: st <= ST_TXRDY;
                default:   st <= st;
            endcase
        end
    end

    // pointers and frame bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            tx_ptr <= '0;
            rx_len <= '0;
            tx_len <= '0;
            rx_bad <= 1'b0;
            pin_q  <= 1'b0;
        end else begin
            pin_q <= tx_pin;
            if (sof_take || cmd_clr || tx_last) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (rx_take || hw_take) wr_ptr <= wr_ptr + 1'b1;
                if (rd_take)            rd_ptr <= rd_ptr + 1'b1;
            end
            if (tx_acc)       tx_ptr <= '0;
            else if (tx_send) tx_ptr <= tx_ptr + 1'b1;
            if (rx_take && wr_ptr == '0) rx_len <= rx_clamp[AW-1:0];
            if (tx_send && tx_ptr == '0) tx_len <= tx_clamp[AW-1:0];
            if (sof_take)  rx_bad <= 1'b0;
            else if (urun) rx_bad <= 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            hst_rdata <= '0;
            tx_stb    <= 1'b0;
            tx_byte   <= '0;
        end else begin
            tx_stb  <= tx_send;
            tx_byte <= tx_send ? tx_cur : 8'd0;
            if (hst_rd) begin
                case (hst_addr)
                    A_STAT:  hst_rdata <= {{(8-NIRQ){1'b0}}, pend};
                    A_MASK:  hst_rdata <= {{(8-NIRQ){1'b0}}, mask};
                    A_CTRL:  hst_rdata <= {rx_bad, 4'b0, st};
                    default: hst_rdata <= rd_take ? rd_data : 8'd0;
                endcase
            end
        end
    end

    assign buf_empty = (rd_ptr == wr_ptr);

    // R3: frame start is taken in the listening state
    a_r3_frame_start: assert property (@(posedge clk) disable iff (rst)
        sof_take |=> (st == ST_BRX && pend[0]));
    // R7: the host never reads beyond the stored data
    a_r7_rd_behind_wr: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= wr_ptr);
    // R5: reads inside the guard window leave the read pointer alone
    a_r5_guard_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_buf && !rd_open && !sof_take && !cmd_clr && !tx_last) |=> $stable(rd_ptr));
    // R6: an overtaking read in busy-receive is flagged
    a_r6_underrun: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BRX && rd_buf && rd_open && rd_ptr == wr_ptr && !rx_take) |=> (pend[2] && rx_bad));
    // R9: transmit start outside the ready states has no effect
    a_r9_tx_ignored: assert property (@(posedge clk) disable iff (rst)
        (tx_go && (st == ST_IDLE || st == ST_RXON) && !rx_sof) |=> (st != ST_BTX));
    // R10: transmit strobes only during or just after busy-transmit
    a_r10_tx_in_busy: assert property (@(posedge clk) disable iff (rst)
        tx_stb |-> ($past(st) == ST_BTX));
endmodule

// File: tb/rfbuf_irq_ctrl_tb.sv
`timescale 1ns/1ps
module rfbuf_irq_ctrl_tb_top;
    localparam int G = 100;  // 50 MHz x 2 us guard for the bench

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hst_wr = 0, hst_rd = 0;
    logic [1:0] hst_addr = 0;
    logic [7:0] hst_wdata = 0;
    logic [7:0] hst_rdata;
    logic rx_sof = 0, rx_vld = 0;
    logic [7:0] rx_byte = 0;
    logic tx_pin = 0;
    logic tx_stb, buf_empty, irq;
    logic [7:0] tx_byte;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] cap [256];
    int ncap = 0;
    logic [7:0] frm [256];

    always #10 clk = ~clk;

    rfbuf_irq_ctrl #(.DEPTH(128), .CLK_MHZ(50), .GUARD_US(2)) dut_i (
        .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_byte(rx_byte),
        .tx_pin(tx_pin), .tx_stb(tx_stb), .tx_byte(tx_byte),
        .buf_empty(buf_empty), .irq(irq)
    );

    always @(negedge clk) begin
        if (tx_stb) begin
            cap[ncap[7:0]] = tx_byte;
            ncap = ncap + 1;
        end
    end

    function automatic int exp_len(input logic [7:0] b);
        return (b > 8'd127) ? 127 : int'(b);
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        hst_wr = 1; hst_addr = a; hst_wdata = d;
        tick();
        hst_wr = 0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [7:0] d);
        hst_rd = 1; hst_addr = a;
        tick();
        hst_rd = 0;
        d = hst_rdata;
    endtask

    task automatic sof();
        rx_sof = 1; tick(); rx_sof = 0;
    endtask

    task automatic put(input logic [7:0] b);
        rx_vld = 1; rx_byte = b; tick(); rx_vld = 0;
    endtask

    task automatic pulse_pin();
        tx_pin = 1; tick(); tx_pin = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int seed;
        seed = $urandom(20250611);
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 buf_empty", int'(buf_empty), 1);
        chk("R1 tx_stb", int'(tx_stb), 0);
        hr(2'd2, d); chk("R1 state", int'(d), 0);
        hr(2'd1, d); chk("R1 mask", int'(d), 7);
        hr(2'd0, d); chk("R1 pend", int'(d), 0);

        // R2 mask register
        hw(2'd1, 8'd6);
        hr(2'd1, d); chk("R2 mask rw", int'(d), 6);

        // R11 listen, R9 tx start ignored there
        hw(2'd2, 8'd3);
        hr(2'd2, d); chk("R11 rxon", int'(d), 2);
        hw(2'd2, 8'd2);
        hr(2'd2, d); chk("R9 tx ignored in rxon", int'(d), 2);

        // R3 frame start, masked -> R8 irq low
        sof();
        chk("R8 masked irq", int'(irq), 0);
        hr(2'd0, d); chk("R3 start flag", int'(d), 1);
        hr(2'd0, d); chk("R8 cleared", int'(d), 0);
        hr(2'd2, d); chk("R3 busy rx", int'(d), 3);
        hw(2'd1, 8'd7);

        // R5 early read ignored
        hr(2'd3, d); chk("R5 early read", int'(d), 0);
        hr(2'd0, d); chk("R5 no underrun in guard", int'(d), 0);

        // R6 underrun after guard
        repeat (G + 2) tick();
        hr(2'd3, d); chk("R6 underrun data", int'(d), 0);
        chk("R8 irq on underrun", int'(irq), 1);
        chk("R7 empty", int'(buf_empty), 1);
        hr(2'd0, d); chk("R6 underrun flag", int'(d), 4);
        chk("R8 irq after clear", int'(irq), 0);
        hr(2'd2, d); chk("R6 suspect bit", int'(d), 8'h83);

        // R4 / R7 read while arriving
        put(8'd3);
        chk("R7 not empty", int'(buf_empty), 0);
        hr(2'd3, d); chk("R4 len byte", int'(d), 3);
        chk("R7 empty again", int'(buf_empty), 1);
        put(8'hA1); put(8'hB2);
        hr(2'd3, d); chk("R4 byte a", int'(d), 8'hA1);
        hr(2'd0, d); chk("R4 no end yet", int'(d), 0);
        put(8'hC3);
        hr(2'd0, d); chk("R4 end flag", int'(d), 2);
        hr(2'd2, d); chk("R4 back to rxon", int'(d), 8'h82);
        hr(2'd3, d); chk("R4 byte b", int'(d), 8'hB2);
        hr(2'd3, d); chk("R4 byte c", int'(d), 8'hC3);
        chk("R7 drained", int'(buf_empty), 1);

        // R4 random receive frames
        for (int f = 0; f < 5; f++) begin
            int len;
            len = int'($urandom_range(0, 20));
            frm[0] = 8'(len);
            for (int i = 1; i <= len; i++) frm[i] = 8'($urandom);
            sof();
            for (int i = 0; i <= len; i++) begin
                repeat ($urandom_range(0, 2)) tick();
                put(frm[i]);
            end
            repeat (G + 2) tick();
            hr(2'd0, d); chk("R4 rand flags", int'(d), 3);
            for (int i = 0; i <= len; i++) begin
                hr(2'd3, d); chk("R4 rand data", int'(d), int'(frm[i]));
            end
            hr(2'd3, d); chk("R6 overread outside busy", int'(d), 0);
            hr(2'd0, d); chk("R6 no flag outside busy", int'(d), 0);
        end

        // R4 length clamp
        sof();
        put(8'hC8);
        for (int i = 0; i < exp_len(8'hC8) - 1; i++) put(8'(i));
        hr(2'd0, d); chk("R4 clamp not ended", int'(d), 1);
        put(8'h55);
        hr(2'd0, d); chk("R4 clamp end", int'(d), 2);
        hr(2'd2, d); chk("R4 clamp state", int'(d) & 7, 2);

        // R9 / R10 pin start from PLL-on
        hw(2'd2, 8'd1);
        hr(2'd2, d); chk("R11 pll", int'(d) & 7, 1);
        frm[0] = 8'd3;
        for (int i = 1; i <= 3; i++) frm[i] = 8'($urandom);
        for (int i = 0; i <= 3; i++) hw(2'd3, frm[i]);
        ncap = 0;
        pulse_pin();
        repeat (8) tick();
        chk("R10 pin count", ncap, 4);
        for (int i = 0; i < 4; i++) chk("R10 pin data", int'(cap[i]), int'(frm[i]));
        hr(2'd0, d); chk("R10 end flag", int'(d), 2);
        hr(2'd2, d); chk("R10 back to pll", int'(d) & 7, 1);

        // R10 parallel load from transmit-ready, R11 busy ignores command
        hw(2'd2, 8'd5);
        ncap = 0;
        hw(2'd2, 8'd2);
        hr(2'd2, d); chk("R9 cmd start", int'(d) & 7, 4);
        frm[0] = 8'd4;
        for (int i = 1; i <= 4; i++) frm[i] = 8'($urandom);
        hw(2'd3, frm[0]);
        hw(2'd2, 8'd3);
        hr(2'd2, d); chk("R11 busy ignores cmd", int'(d) & 7, 4);
        for (int i = 1; i <= 4; i++) begin
            repeat ($urandom_range(0, 3)) tick();
            hw(2'd3, frm[i]);
        end
        repeat (4) tick();
        chk("R10 par count", ncap, 5);
        for (int i = 0; i < 5; i++) chk("R10 par data", int'(cap[i]), int'(frm[i]));
        hr(2'd2, d); chk("R10 back to txrdy", int'(d) & 7, 5);

        // R10 random transmit frames
        for (int f = 0; f < 4; f++) begin
            int len;
            len = int'($urandom_range(1, 30));
            frm[0] = 8'(len);
            for (int i = 1; i <= len; i++) frm[i] = 8'($urandom);
            hw(2'd2, 8'd1);
            for (int i = 0; i <= len; i++) hw(2'd3, frm[i]);
            ncap = 0;
            hw(2'd2, 8'd2);
            repeat (len + 4) tick();
            chk("R10 rand count", ncap, len + 1);
            for (int i = 0; i <= len; i++) chk("R10 rand data", int'(cap[i]), int'(frm[i]));
            hr(2'd0, d); chk("R10 rand end", int'(d), 2);
        end

        // R9 pin ignored in idle
        hw(2'd2, 8'd4);
        ncap = 0;
        pulse_pin();
        repeat (3) tick();
        hr(2'd2, d); chk("R9 pin ignored idle", int'(d) & 7, 0);
        chk("R9 no tx in idle", ncap, 0);

        finish_run();
    end
endmodule